// File: doc/BRIEF.md
# Symbolic Store-to-Load Address Comparator

This block decides, before any real address exists, whether a load may take its data from an older in-flight store. Every address is held in symbolic form: a physical base register tag plus a signed constant offset, with an access size. Stores enter a small in-order queue and leave it, oldest first, when they commit. Each load query is compared against every queued store. Each pair is graded as a certain match, a certain independence, or unknown. These grades are then reduced to one registered result: forward the data of the youngest matching store, proceed with no conflict, or wait because aliasing cannot be ruled out.

The store input and the load query are valid/ready streams, and the result is a valid/ready stream. A store is taken when `st_valid` and `st_ready` are both high. `st_ready` falls only when the queue is full. A load is taken when `ld_valid` and `ld_ready` are both high. `ld_ready` is high whenever the result register is empty or is being drained in the same cycle. A result waiting with `res_ready` low stays frozen and holds back further loads. `commit` is a plain pulse that frees the oldest store. Aliasing through different virtual mappings is not examined here; such cases are left to a later replay.

Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Result kind codes are 0 = clear, 1 = forward, 2 = wait.

Top module: `symaddr_disambig`

## Requirements
- R1: After reset, `res_valid` is 0, and `st_ready` and `ld_ready` are 1, with no stores held.
- R2: `st_ready` is 0 exactly while DEPTH stores are held. A store offered while full is dropped. `commit` frees the oldest store, and a `commit` with no stores held has no effect.
- R3: For a store with the same base tag, the same offset, and a size code not below the load's, the result is kind 1. The data is the store data cut to the load's byte count (low bytes) and zero-extended.
- R4: A queued store whose base tag differs from the load's makes the result kind 2.
- R5: A same-base store is independent when the magnitude of the signed offset difference is at least the larger of the two byte counts. If every held store is independent, or none is held, the result is kind 0 with data 0.
- R6: A same-base store that is neither independent nor an exact match gives kind 2 and no forwarding. This covers partial overlap, and equal offsets with a wider load.
- R7: Any unknown store gives kind 2, even if another store matches.
- R8: When several stores match and none is unknown, the data comes from the youngest one.
- R9: The result appears one cycle after the load is accepted. While `res_valid` is 1 and `res_ready` is 0, the kind and data hold steady and `ld_ready` is 0.
- R10: A load is judged against the queue as it stood before the same cycle's store push and commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store entry offered |
| st_ready | output | 1 | Queue can take a store |
| st_base | input | TAG_W | Store base register tag |
| st_off | input | OFF_W | Store signed offset |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data |
| commit | input | 1 | Free the oldest store |
| ld_valid | input | 1 | Load query offered |
| ld_ready | output | 1 | Query can be taken |
| ld_base | input | TAG_W | Load base register tag |
| ld_off | input | OFF_W | Load signed offset |
| ld_size | input | 2 | Load size code |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_kind | output | 2 | 0 clear, 1 forward, 2 wait |
| res_data | output | 64 | Forwarded data, zero unless forwarding |

## Verification
The load query can coincide with a store push or with a commit in the same cycle. The bench provokes both. It raises `commit` and `ld_valid` together while the only queued store matches. It then raises `st_valid` and `ld_valid` together on an empty queue with a matching store. The first must forward and the second must report clear, which shows that the load saw the queue as it was before that edge. A later load then confirms that the pushed store was kept.

// File: rtl/symaddr_pkg.sv
package symaddr_pkg;
  localparam int SIZE_W    = 2;
  localparam int MAX_BYTES = 1 << ((1 << SIZE_W) - 1);
  localparam int DATA_W    = 8 * MAX_BYTES;

  typedef enum logic [1:0] {
    KIND_CLEAR = 2'd0,
    KIND_FWD   = 2'd1,
    KIND_WAIT  = 2'd2
  } res_kind_e;

  typedef enum logic [1:0] {
    PAIR_NONE  = 2'd0,
    PAIR_INDEP = 2'd1,
    PAIR_MATCH = 2'd2,
    PAIR_UNK   = 2'd3
  } pair_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (b < (1 << sz)) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction
endpackage

// File: rtl/symaddr_store_q.sv
module symaddr_store_q
  import symaddr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 7,
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TAG_W-1:0]  push_base,
  input  logic [OFF_W-1:0]  push_off,
  input  logic [SIZE_W-1:0] push_size,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              ord_valid [DEPTH],
  output logic [TAG_W-1:0]  ord_base  [DEPTH],
  output logic [OFF_W-1:0]  ord_off   [DEPTH],
  output logic [SIZE_W-1:0] ord_size  [DEPTH],
  output logic [DATA_W-1:0] ord_data  [DEPTH]
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]  mem_base [DEPTH];
  logic [OFF_W-1:0]  mem_off  [DEPTH];
  logic [SIZE_W-1:0] mem_size [DEPTH];
  logic [DATA_W-1:0] mem_data [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  tail;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] wrap_add(input int a, input int b);
    int s;
    s = a + b;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (cnt_q != '0);
  assign tail    = wrap_add(int'(head_q), int'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_ok) head_q <= wrap_add(int'(head_q), 1);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_base[tail] <= push_base;
      mem_off[tail]  <= push_off;
      mem_size[tail] <= push_size;
      mem_data[tail] <= push_data;
    end
  end

  // Present entries oldest first; slot k is valid when k stores precede it.
  for (genvar k = 0; k < DEPTH; k++) begin : g_order
    logic [PTR_W-1:0] src;
    assign src          = wrap_add(int'(head_q), k);
    assign ord_valid[k] = (CNT_W'(k) < cnt_q);
    assign ord_base[k]  = mem_base[src];
    assign ord_off[k]   = mem_off[src];
    assign ord_size[k]  = mem_size[src];
    assign ord_data[k]  = mem_data[src];
  end
endmodule

// File: rtl/symaddr_pair_cls.sv
module symaddr_pair_cls
  import symaddr_pkg::*;
#(
  parameter int TAG_W = 7,
  parameter int OFF_W = 12
) (
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_base,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [SIZE_W-1:0] st_size,
  input  logic [TAG_W-1:0]  ld_base,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [SIZE_W-1:0] ld_size,
  output pair_e             grade
);
  logic              same_base;
  logic [OFF_W:0]    diff;
  logic [OFF_W:0]    mag;
  logic [SIZE_W-1:0] wide_sz;
  logic [OFF_W:0]    span;

  assign same_base = (st_base == ld_base);
  assign diff      = {ld_off[OFF_W-1], ld_off} - {st_off[OFF_W-1], st_off};
  assign mag       = diff[OFF_W] ? (~diff + 1'b1) : diff;
  assign wide_sz   = (ld_size > st_size) ? ld_size : st_size;
  assign span      = (OFF_W + 1)'(1) << wide_sz;

  always_comb begin
    if (!st_valid)                                   grade = PAIR_NONE;
    else if (!same_base)                             grade = PAIR_UNK;
    else if ((diff == '0) && (ld_size <= st_size))   grade = PAIR_MATCH;
    else if (mag >= span)                            grade = PAIR_INDEP;
    else                                             grade = PAIR_UNK;
  end
endmodule

// File: rtl/symaddr_select.sv
module symaddr_select
  import symaddr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  pair_e             grade    [DEPTH],
  input  logic [DATA_W-1:0] st_data  [DEPTH],
  input  logic [SIZE_W-1:0] ld_size,
  output res_kind_e         kind,
  output logic [DATA_W-1:0] data
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             any_unk;
  logic             hit;
  logic [SEL_W-1:0] sel;

  always_comb begin
    any_unk = 1'b0;
    hit     = 1'b0;
    sel     = '0;
    // Ascending age order: the last match seen is the youngest.
    for (int k = 0; k < DEPTH; k++) begin
      if (grade[k] == PAIR_UNK) any_unk = 1'b1;
      if (grade[k] == PAIR_MATCH) begin
        hit = 1'b1;
        sel = SEL_W'(k);
      end
    end
  end

  always_comb begin
    if (any_unk) begin
      kind = KIND_WAIT;
      data = '0;
    end else if (hit) begin
      kind = KIND_FWD;
      data = st_data[sel] & size_mask(ld_size);
    end else begin
      kind = KIND_CLEAR;
      data = '0;
    end
  end
endmodule

// File: rtl/symaddr_disambig.sv
module symaddr_disambig
  import symaddr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 7,
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [TAG_W-1:0]  st_base,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [1:0]        st_size,
  input  logic [63:0]       st_data,
  input  logic              commit,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [TAG_W-1:0]  ld_base,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [1:0]        ld_size,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_kind,
  output logic [63:0]       res_data
);
  logic              full;
  logic              q_valid [DEPTH];
  logic [TAG_W-1:0]  q_base  [DEPTH];
  logic [OFF_W-1:0]  q_off   [DEPTH];
  logic [SIZE_W-1:0] q_size  [DEPTH];
  logic [DATA_W-1:0] q_data  [DEPTH];
  pair_e             grade   [DEPTH];
  res_kind_e         pick_kind;
  logic [DATA_W-1:0] pick_data;
  logic              ld_fire;
  logic              rv_q;
  res_kind_e         kind_q;
  logic [DATA_W-1:0] data_q;

  assign st_ready = !full;
  assign ld_ready = !rv_q || res_ready;
  assign ld_fire  = ld_valid && ld_ready;

  symaddr_store_q #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_valid && st_ready),
    .push_base (st_base),
    .push_off  (st_off),
    .push_size (st_size),
    .push_data (st_data),
    .pop       (commit),
    .full      (full),
    .ord_valid (q_valid),
    .ord_base  (q_base),
    .ord_off   (q_off),
    .ord_size  (q_size),
    .ord_data  (q_data)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    symaddr_pair_cls #(.TAG_W(TAG_W), .OFF_W(OFF_W)) u_pair (
      .st_valid (q_valid[k]),
      .st_base  (q_base[k]),
      .st_off   (q_off[k]),
      .st_size  (q_size[k]),
      .ld_base  (ld_base),
      .ld_off   (ld_off),
      .ld_size  (ld_size),
      .grade    (grade[k])
    );
  end

  symaddr_select #(.DEPTH(DEPTH)) u_pick (
    .grade   (grade),
    .st_data (q_data),
    .ld_size (ld_size),
    .kind    (pick_kind),
    .data    (pick_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      kind_q <= KIND_CLEAR;
      data_q <= '0;
    end else if (ld_fire) begin
      rv_q   <= 1'b1;
      kind_q <= pick_kind;
      data_q <= pick_data;
    end else if (res_ready) begin
      rv_q   <= 1'b0;
    end
  end

  assign res_valid = rv_q;
  assign res_kind  = kind_q;
  assign res_data  = data_q;
endmodule

// File: rtl/symaddr_disambig_chk.sv
module symaddr_disambig_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        st_valid,
  input logic        st_ready,
  input logic        commit,
  input logic        ld_valid,
  input logic        ld_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic [1:0]  res_kind,
  input logic [63:0] res_data
);
  int occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + ((st_valid && st_ready) ? 1 : 0) - ((commit && occ != 0) ? 1 : 0);
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH) |-> !st_ready);                                          // R2
  AST_ROOM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < DEPTH) |-> st_ready);                                            // R2
  AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && occ == 0) |=> (res_valid && res_kind == 2'd0)); // R5
  AST_NOFWD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != 2'd1) |-> (res_data == 64'd0));                // R5
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_kind != 2'd3));                                       // R9
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_kind) && $stable(res_data))); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !ld_ready);                                // R9
  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> res_valid);                                   // R9
endmodule

bind symaddr_disambig symaddr_disambig_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .commit    (commit),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_kind  (res_kind),
  .res_data  (res_data)
);

// File: tb/symaddr_disambig_bench.sv
module symaddr_disambig_bench;
  localparam int DEPTH = 4;
  localparam int TAG_W = 7;
  localparam int OFF_W = 12;
  localparam logic [63:0] SD = 64'h8877_6655_4433_2211;

  typedef struct packed {
    logic [TAG_W-1:0] sb;
    logic [OFF_W-1:0] so;
    logic [1:0]       ss;
    logic [TAG_W-1:0] lb;
    logic [OFF_W-1:0] lo;
    logic [1:0]       ls;
    logic [1:0]       ek;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{7'd5, 12'd16,    2'd3, 7'd5, 12'd16,    2'd3, 2'd1},  // R3 exact
    '{7'd5, 12'd16,    2'd3, 7'd5, 12'd16,    2'd0, 2'd1},  // R3 narrow load
    '{7'd5, 12'd16,    2'd1, 7'd5, 12'd16,    2'd2, 2'd2},  // R6 wider load
    '{7'd5, 12'd16,    2'd3, 7'd6, 12'd16,    2'd3, 2'd2},  // R4 other base
    '{7'd5, 12'd16,    2'd2, 7'd5, 12'd20,    2'd2, 2'd0},  // R5 adjacent above
    '{7'd5, 12'd16,    2'd2, 7'd5, 12'd19,    2'd0, 2'd2},  // R6 partial
    '{7'd5, 12'd20,    2'd0, 7'd5, 12'd16,    2'd2, 2'd0},  // R5 adjacent below
    '{7'd5, 12'd100,   2'd3, 7'd5, 12'd92,    2'd3, 2'd0},  // R5 gap equals size
    '{7'd5, 12'd100,   2'd3, 7'd5, 12'd93,    2'd0, 2'd2},  // R6 inside
    '{7'd5, 12'hFF8,   2'd3, 7'd5, 12'hFF8,   2'd2, 2'd1},  // R3 negative offset
    '{7'd5, 12'h7FF,   2'd3, 7'd5, 12'h800,   2'd3, 2'd0}   // R5 extreme signed gap
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, commit = 1'b0, ld_valid = 1'b0, res_ready = 1'b1;
  logic [TAG_W-1:0] st_base = '0, ld_base = '0;
  logic [OFF_W-1:0] st_off = '0, ld_off = '0;
  logic [1:0] st_size = '0, ld_size = '0;
  logic [63:0] st_data = '0;
  logic st_ready, ld_ready, res_valid;
  logic [1:0] res_kind;
  logic [63:0] res_data;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  symaddr_disambig #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_symaddr_disambig (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_base(st_base), .st_off(st_off),
    .st_size(st_size), .st_data(st_data), .commit(commit),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_base(ld_base), .ld_off(ld_off),
    .ld_size(ld_size), .res_valid(res_valid), .res_ready(res_ready),
    .res_kind(res_kind), .res_data(res_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [TAG_W-1:0] b, input logic [OFF_W-1:0] o,
                      input logic [1:0] s, input logic [63:0] d);
    st_valid = 1'b1; st_base = b; st_off = o; st_size = s; st_data = d;
    step();
    st_valid = 1'b0;
  endtask

  task automatic pop();
    commit = 1'b1;
    step();
    commit = 1'b0;
  endtask

  task automatic load(input logic [TAG_W-1:0] b, input logic [OFF_W-1:0] o,
                      input logic [1:0] s);
    ld_valid = 1'b1; ld_base = b; ld_off = o; ld_size = s;
    step();
    ld_valid = 1'b0;
  endtask

  function automatic logic [63:0] cut(input logic [63:0] d, input logic [1:0] s);
    return d & ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", 64'(res_valid), 64'd0);
    chk("R1 st_ready", 64'(st_ready), 64'd1);
    chk("R1 ld_ready", 64'(ld_ready), 64'd1);
    load(7'd5, 12'd0, 2'd3);
    chk("R5 empty kind", 64'(res_kind), 64'd0);

    // Vector table: one store, one load, then commit
    for (int i = 0; i < NV; i++) begin
      logic [63:0] d;
      d = SD ^ 64'(i);
      push(VEC[i].sb, VEC[i].so, VEC[i].ss, d);
      load(VEC[i].lb, VEC[i].lo, VEC[i].ls);
      chk($sformatf("R3-6 vec%0d valid", i), 64'(res_valid), 64'd1);
      chk($sformatf("R3-6 vec%0d kind", i), 64'(res_kind), 64'(VEC[i].ek));
      chk($sformatf("R3-6 vec%0d data", i), res_data,
          (VEC[i].ek == 2'd1) ? cut(d, VEC[i].ls) : 64'd0);
      pop();
    end

    // R2 commit on empty has no effect, then fill
    pop();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 room before full", 64'(st_ready), 64'd1);
      push(7'(10 + i), 12'd0, 2'd3, 64'(i));
    end
    chk("R2 full stall", 64'(st_ready), 64'd0);
    push(7'd20, 12'd0, 2'd3, 64'hDEAD);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R2 drained ready", 64'(st_ready), 64'd1);
    load(7'd20, 12'd0, 2'd3);
    chk("R2 dropped store kind", 64'(res_kind), 64'd0);

    // R8 youngest match wins
    push(7'd3, 12'd0, 2'd3, 64'hA1);
    push(7'd3, 12'd0, 2'd3, 64'hB2);
    push(7'd3, 12'd64, 2'd3, 64'hC3);
    load(7'd3, 12'd0, 2'd3);
    chk("R8 kind", 64'(res_kind), 64'd1);
    chk("R8 youngest data", res_data, 64'hB2);
    pop();
    load(7'd3, 12'd0, 2'd3);
    chk("R8 after commit data", res_data, 64'hB2);
    pop(); pop();
    load(7'd3, 12'd0, 2'd3);
    chk("R8 all freed kind", 64'(res_kind), 64'd0);

    // R7 unknown overrides a match, both orders
    push(7'd3, 12'd0, 2'd3, 64'h11);
    push(7'd4, 12'd0, 2'd3, 64'h22);
    load(7'd3, 12'd0, 2'd3);
    chk("R7 match then unknown", 64'(res_kind), 64'd2);
    pop();
    push(7'd3, 12'd0, 2'd3, 64'h33);
    load(7'd3, 12'd0, 2'd3);
    chk("R7 unknown then match", 64'(res_kind), 64'd2);
    pop(); pop();

    // R9 back-pressure
    push(7'd5, 12'd0, 2'd3, 64'h55);
    res_ready = 1'b0;
    ld_valid = 1'b1; ld_base = 7'd9; ld_off = 12'd0; ld_size = 2'd3;
    step();
    chk("R9 result after one cycle", 64'(res_valid), 64'd1);
    chk("R9 stall ld_ready", 64'(ld_ready), 64'd0);
    ld_base = 7'd5;
    step();
    chk("R9 held kind", 64'(res_kind), 64'd2);
    chk("R9 held valid", 64'(res_valid), 64'd1);
    res_ready = 1'b1;
    step();
    ld_valid = 1'b0;
    chk("R9 next load kind", 64'(res_kind), 64'd1);
    chk("R9 next load data", res_data, 64'h55);
    step();
    chk("R9 drained", 64'(res_valid), 64'd0);

    // R10 same-cycle commit and load, then push and load
    commit = 1'b1;
    ld_valid = 1'b1; ld_base = 7'd5; ld_off = 12'd0; ld_size = 2'd1;
    step();
    commit = 1'b0; ld_valid = 1'b0;
    chk("R10 commit+load kind", 64'(res_kind), 64'd1);
    chk("R10 commit+load data", res_data, 64'h55);
    st_valid = 1'b1; st_base = 7'd6; st_off = 12'd8; st_size = 2'd3; st_data = 64'h66;
    ld_valid = 1'b1; ld_base = 7'd6; ld_off = 12'd8; ld_size = 2'd3;
    step();
    st_valid = 1'b0; ld_valid = 1'b0;
    chk("R10 push+load kind", 64'(res_kind), 64'd0);
    load(7'd6, 12'd8, 2'd3);
    chk("R10 pushed store kept", res_data, 64'h66);
    pop();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule